// File: doc/BRIEF.md
# Hierarchical Unsigned Magnitude Comparator

This block compares two unsigned operands and reports two flags: one that is high when the operands are equal and one that is high when operand A is strictly smaller than operand B. When both flags are low, A is the larger value. No separate greater-than flag exists. The block is purely combinational, with no clock and no state, so the flags follow the operands within the same cycle.

The operands are cut into 2-bit slices. A small leaf cell compares each pair of slices with two-level logic. Merge cells then join the leaf results in groups of four, and repeat that step at each higher level of the tree. A merge cell looks at its groups from the most significant one down. Its equal flag is the AND of the four group equal flags. Its less-than flag is set by the highest group that is not equal.

The default width is 32 bits, which gives 16 leaves and two merge levels. The width parameter accepts any value of the form 2·4^k, such as 8, 128 or 512. The tree depth grows as log4 of the width.

Top module: `ucmp_tree_top`

## Requirements
- R1: Both operands are unsigned: 32'h8000_0000 compared with 32'h7FFF_FFFF gives isEq=0 and isLt=0.
- R2: isEq is 1 exactly when opA equals opB in every bit.
- R3: isLt is 1 exactly when opA is less than opB as unsigned integers.
- R4: isEq and isLt are never both 1.
- R5: When opA is greater than opB, both isEq and isLt are 0.
- R6: Operands that differ only in bit 0 are resolved correctly, with isLt equal to bit 0 of opB.
- R7: The most significant unequal 8-bit group decides isLt, whatever the lower groups hold.
- R8: The same tree is correct for other widths of the form 2·4^k. At WIDTH=8, all 65536 operand pairs give flags that match a behavioural compare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First unsigned operand |
| opB | input | WIDTH | Second unsigned operand |
| isEq | output | 1 | High when opA equals opB |
| isLt | output | 1 | High when opA is less than opB |

## Verification
Random operands almost never share their upper groups. As a result, the deep chain of a merge cell, where every higher group is equal and only the lowest slice decides, is hard to reach from the ports. The bench reaches it in three ways. It uses directed pairs that differ only in bit 0 or by plus or minus one. It uses random pairs built by copying opA and flipping a single randomly chosen bit. It also runs an exhaustive sweep of an 8-bit copy of the tree, which drives every leaf and merge path through every slice combination.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  typedef struct packed {
    logic eq;
    logic lt;
  } cmpFlags_t;

  // number of radix-4 merge levels above LEAVES leaf cells
  function automatic int mergeLevels(input int leaves);
    int n;
    int lv;
    n = leaves;
    lv = 0;
    while (n > 1) begin
      n = n / 4;
      lv = lv + 1;
    end
    return lv;
  endfunction

  // index of the first node of level lvl in the flat node array
  function automatic int nodeBase(input int lvl, input int leaves);
    int base;
    int n;
    base = 0;
    n = leaves;
    for (int k = 0; k < lvl; k++) begin
      base = base + n;
      n = n / 4;
    end
    return base;
  endfunction

endpackage

// File: rtl/cmp_leaf.sv
module cmp_leaf (
  input  logic [1:0] sliceA,
  input  logic [1:0] sliceB,
  output logic       leafEq,
  output logic       leafLt
);
  logic hiSame;
  logic loSame;

  always_comb begin
    hiSame = ~(sliceA[1] ^ sliceB[1]);
    loSame = ~(sliceA[0] ^ sliceB[0]);
    leafEq = hiSame & loSame;
    leafLt = (~sliceA[1] & sliceB[1]) | (hiSame & ~sliceA[0] & sliceB[0]);
  end
endmodule

// File: rtl/cmp_merge.sv
module cmp_merge #(
  parameter int RADIX = 4
) (
  input  logic [RADIX-1:0] grpEq,
  input  logic [RADIX-1:0] grpLt,
  output logic             mrgEq,
  output logic             mrgLt
);
  // group RADIX-1 is the most significant
  always_comb begin
    logic upperSame;
    upperSame = 1'b1;
    mrgLt = 1'b0;
    for (int g = RADIX - 1; g >= 0; g--) begin
      mrgLt = mrgLt | (upperSame & grpLt[g]);
      upperSame = upperSame & grpEq[g];
    end
    mrgEq = upperSame;
  end
endmodule

// File: rtl/cmp_tree.sv
module cmp_tree #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] treeA,
  input  logic [WIDTH-1:0] treeB,
  output logic             rootEq,
  output logic             rootLt
);
  import cmp_pkg::*;

  localparam int RADIX  = 4;
  localparam int LEAVES = WIDTH / 2;
  localparam int LEVELS = mergeLevels(LEAVES);
  localparam int NODES  = nodeBase(LEVELS + 1, LEAVES);
  localparam int ROOT   = nodeBase(LEVELS, LEAVES);

  cmpFlags_t nodeArr [NODES];

  genvar li;
  generate
    for (li = 0; li < LEAVES; li++) begin : g_leaf
      cmp_leaf u_leaf (
        .sliceA (treeA[2*li+1 -: 2]),
        .sliceB (treeB[2*li+1 -: 2]),
        .leafEq (nodeArr[li].eq),
        .leafLt (nodeArr[li].lt)
      );
    end
  endgenerate

  genvar lvl, nj, kc;
  generate
    for (lvl = 1; lvl <= LEVELS; lvl++) begin : g_level
      localparam int CHILD_BASE = nodeBase(lvl - 1, LEAVES);
      localparam int OWN_BASE   = nodeBase(lvl, LEAVES);
      localparam int COUNT      = LEAVES / (RADIX ** lvl);
      for (nj = 0; nj < COUNT; nj++) begin : g_node
        logic [RADIX-1:0] childEq;
        logic [RADIX-1:0] childLt;
        for (kc = 0; kc < RADIX; kc++) begin : g_child
          assign childEq[kc] = nodeArr[CHILD_BASE + RADIX*nj + kc].eq;
          assign childLt[kc] = nodeArr[CHILD_BASE + RADIX*nj + kc].lt;
        end
        cmp_merge #(.RADIX(RADIX)) u_merge (
          .grpEq (childEq),
          .grpLt (childLt),
          .mrgEq (nodeArr[OWN_BASE + nj].eq),
          .mrgLt (nodeArr[OWN_BASE + nj].lt)
        );
      end
    end
  endgenerate

  assign rootEq = nodeArr[ROOT].eq;
  assign rootLt = nodeArr[ROOT].lt;
endmodule

// File: rtl/ucmp_tree_top.sv
module ucmp_tree_top #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             isEq,
  output logic             isLt
);
  cmp_tree #(.WIDTH(WIDTH)) u_tree (
    .treeA  (opA),
    .treeB  (opB),
    .rootEq (isEq),
    .rootLt (isLt)
  );
endmodule

// File: rtl/ucmp_tree_chk.sv
module ucmp_tree_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             isEq,
  input logic             isLt
);
  always_comb begin
    p_never_both_r4: assert (!(isEq && isLt));
    p_eq_matches_r2: assert (isEq == (opA == opB));
    p_lt_unsigned_r3: assert (isLt == (opA < opB));
    p_greater_quiet_r5: assert (!(opA > opB) || (!isEq && !isLt));
    p_lsb_only_r6: assert (!((opA ^ opB) == {{(WIDTH-1){1'b0}}, 1'b1}) || (isLt == opB[0]));
  end
endmodule

bind ucmp_tree_top ucmp_tree_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/ucmp_tree_top_tb_top.sv
module ucmp_tree_top_tb_top;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] opA, opB;
  logic isEq, isLt;
  logic [7:0] smA, smB;
  logic smEq, smLt;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  ucmp_tree_top #(.WIDTH(W)) dut_i (.opA(opA), .opB(opB), .isEq(isEq), .isLt(isLt));
  ucmp_tree_top #(.WIDTH(8)) dut8_i (.opA(smA), .opB(smB), .isEq(smEq), .isLt(smLt));

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         eq;
    logic         lt;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0},
    '{32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b1},
    '{32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b0},
    '{32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 1'b0},
    '{32'h1234_5678, 32'h1234_5679, 1'b0, 1'b1},
    '{32'h1234_5679, 32'h1234_5678, 1'b0, 1'b0},
    '{32'h0100_0000, 32'h00FF_FFFF, 1'b0, 0},
    '{32'h00FF_FFFF, 32'h0100_0000, 1'b0, 1'b1},
    '{32'hABCD_0000, 32'hABCC_FFFF, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic gotEq, input logic gotLt,
                       input logic expEq, input logic expLt);
    checks++;
    if (gotEq !== expEq || gotLt !== expLt) begin
      failures++;
      $display("FAIL %s: got eq=%0b lt=%0b expected eq=%0b lt=%0b (A=%h B=%h)",
               req, gotEq, gotLt, expEq, expLt, opA, opB);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    @(negedge clk);
    opA = a;
    opB = b;
    #1;
    check(req, isEq, isLt, a == b, a < b);
  endtask

  initial begin
    opA = '0; opB = '0; smA = '0; smB = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R2 reset state", isEq, isLt, 1'b1, 1'b0);

    // table walk: R1 signed-looking operands, R2/R3 basics, R5, R7 group priority
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      opA = VECS[i].a;
      opB = VECS[i].b;
      #1;
      check("R1/R2/R3/R5/R7 table", isEq, isLt, VECS[i].eq, VECS[i].lt);
    end

    // R6: differ only in bit 0
    apply(32'hFFFF_FFFE, 32'hFFFF_FFFF, "R6 lsb lt");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFE, "R6 lsb gt");
    apply(32'h0000_0000, 32'h0000_0001, "R6 lsb zero");

    // R4 and R5 explicit
    @(negedge clk); opA = 32'h0000_0005; opB = 32'h0000_0003; #1;
    check("R5 greater gives both low", isEq, isLt, 1'b0, 1'b0);
    checks++;
    if (isEq && isLt) begin failures++; $display("FAIL R4: both flags high, expected at most one"); end

    // R7: upper group decides over contrary lower groups
    apply(32'h0200_0000, 32'h01FF_FFFF, "R7 upper group gt");
    apply(32'h01FF_FFFF, 32'h0200_0000, "R7 upper group lt");

    // random, plus-minus one and single-bit-flip pairs: R2 R3
    for (int i = 0; i < 2000; i++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      ra = $urandom;
      rb = $urandom;
      apply(ra, rb, "R3 random");
      apply(ra, ra, "R2 random equal");
      apply(ra, ra + 1, "R3 plus one");
      apply(ra, ra - 1, "R3 minus one");
      apply(ra, ra ^ (32'h1 << ($urandom % W)), "R7 single bit flip");
    end

    // R8: exhaustive sweep of an 8-bit tree
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        smA = a[7:0];
        smB = b[7:0];
        #1;
        checks++;
        if (smEq !== (a == b) || smLt !== (a < b)) begin
          failures++;
          $display("FAIL R8: A=%0d B=%0d got eq=%0b lt=%0b expected eq=%0b lt=%0b",
                   a, b, smEq, smLt, a == b, a < b);
        end
      end
    end

    done = 1'b1;
  end

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule